// File: doc/BRIEF.md
# Embedded-Clock Word Serializer

This block turns parallel words into a single serial bit stream that carries its own timing. Every word is wrapped between two embedded clock bits, a start bit of 1 in front and a stop bit of 0 behind. A receiver can therefore find word edges and recover its clock from the line alone. The core runs on one fast system clock. A strobe from an external bit-rate timebase marks each bit period, and one serial bit leaves per strobe. Because only the strobe ratio matters, the block works over any word rate the timebase supports.

Words arrive on a valid/ready stream; the arrival of words stands in for the transmit word clock. The block looks for a word only at a frame boundary: the strobe cycle that ends the last bit of a frame, or any strobe cycle while the line is idle. In that cycle `word_ready` is high, and a word is taken when `word_valid` is also high. The word is copied at that moment, so the source may change `word_data` right after the handshake. If no word is offered at a boundary, the word clock has stopped. The line then goes idle (`line_idle` high, `ser_out` low), and the next offered word starts a fresh, complete frame.

Two line-training request inputs are ORed. When either is high at a boundary, the block sends a training frame instead of data and holds off the stream. The training payload is the lower half of the payload bits at one and the upper half at zero. A power-down input that is high stops everything at once. A low level, which is the level the integration must tie it to when unused, means normal operation.

Top module: `emb_clk_serializer`

## Requirements
- R1: A frame is 12 bit periods, each held from one `bit_en` strobe to the next. It starts with a start bit of 1, then carries payload bits 0 to 9 with bit 0 first, and ends with a stop bit of 0. `ser_out` changes only in the clock edge of a `bit_en` strobe or a power-down.
- R2: A word is taken only in a cycle where `word_valid` and `word_ready` are both high. `word_ready` is high only in a `bit_en` cycle at a frame boundary, with `pwr_down` low and both training requests low. Each word taken is sent exactly once, in the order taken.
- R3: The frame carries the word value seen at the handshake. Changes to `word_data` after the handshake do not alter the frame in flight.
- R4: If `train_req_a` or `train_req_b` is high at a boundary, a training frame is sent. Its payload bits 0 to 4 are 1 and bits 5 to 9 are 0, inside the normal start and stop bits. No word is taken while either request is high.
- R5: A training request raised in the middle of a frame does not change that frame. It takes effect at the next boundary.
- R6: If no word is offered at a boundary, `line_idle` goes high and `ser_out` low. The next offered word is sent as a complete frame, starting at the following boundary strobe.
- R7: While `pwr_down` is high, the frame in flight is abandoned and no word is taken. From the next cycle on, `line_idle` is high and `ser_out` is low. After release, the next frame begins with its start bit.
- R8: After reset, `line_idle` is high and `ser_out` is low.
- R9: When a word is offered at every boundary, frames follow each other with no idle bit period between them (frame starts 12 strobes apart).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per serial bit period |
| word_valid | input | 1 | A parallel word is offered |
| word_ready | output | 1 | Word is taken this cycle if valid |
| word_data | input | 10 | Parallel payload word |
| train_req_a | input | 1 | Training frame request, ORed with the other |
| train_req_b | input | 1 | Training frame request, ORed with the other |
| pwr_down | input | 1 | High stops and clears the serializer |
| ser_out | output | 1 | Serial line bit |
| line_idle | output | 1 | High when no frame is being sent |

## Verification
The scoreboard decodes every frame from the line. It rejects a wrong start or stop bit, which catches a shifter that swaps bit order or drops a clock bit. It also rejects any payload that is neither the next expected word nor a training frame sent within a training window. A design that sampled the word late shows up through the corrupted data driven right after each handshake. A design that acted on a training request mid-frame would cut the word in flight, and one that took data during training would lose the word held on the stream. Power-down is raised mid-frame to show the partial frame is dropped and the line goes quiet. A burst checks that frame starts stay exactly 12 strobes apart, which a design wasting a strobe at each boundary would fail.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // What the shifter does at the next clock edge.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_DATA  = 2'd1,
    ACT_TRAIN = 2'd2,
    ACT_IDLE  = 2'd3
  } shift_act_e;
endpackage

// File: rtl/ser_frame_fmt.sv
module ser_frame_fmt #(
  parameter int PAY_W = 10
) (
  input  logic [PAY_W-1:0] pay_in,
  input  logic             train,
  output logic [PAY_W+1:0] frame
);
  localparam int HALF = PAY_W / 2;

  logic [PAY_W-1:0] pay_sel;

  // Training payload: lower half ones (sent first), upper half zeros.
  for (genvar i = 0; i < PAY_W; i++) begin : g_bit
    if (i < HALF) begin : g_lo
      assign pay_sel[i] = train | pay_in[i];
    end else begin : g_hi
      assign pay_sel[i] = ~train & pay_in[i];
    end
  end

  // LSB leaves first: start bit, payload, stop bit.
  assign frame = {1'b0, pay_sel, 1'b1};
endmodule

// File: rtl/ser_word_ctl.sv
module ser_word_ctl
  import ser_pkg::*;
(
  input  logic       bit_en,
  input  logic       at_boundary,
  input  logic       pwr_down,
  input  logic       train_req_a,
  input  logic       train_req_b,
  input  logic       word_valid,
  output logic       word_ready,
  output shift_act_e act
);
  logic take_slot;
  logic train_any;

  assign take_slot  = bit_en & at_boundary & ~pwr_down;
  assign train_any  = train_req_a | train_req_b;
  assign word_ready = take_slot & ~train_any;

  always_comb begin
    act = ACT_HOLD;
    if (take_slot) begin
      if (train_any)       act = ACT_TRAIN;
      else if (word_valid) act = ACT_DATA;
      else                 act = ACT_IDLE;
    end
  end
endmodule

// File: rtl/ser_bit_shifter.sv
module ser_bit_shifter
  import ser_pkg::*;
#(
  parameter int FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               pwr_down,
  input  shift_act_e         act,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               ser_out,
  output logic               line_idle,
  output logic               at_boundary
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic               active;

  assign at_boundary = ~active | (cnt == LAST);
  assign ser_out     = active & shreg[0];
  assign line_idle   = ~active;

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_down) begin
      shreg  <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else begin
      unique case (act)
        ACT_DATA, ACT_TRAIN: begin
          shreg  <= frame_in;
          cnt    <= '0;
          active <= 1'b1;
        end
        ACT_IDLE: begin
          shreg  <= '0;
          cnt    <= '0;
          active <= 1'b0;
        end
        default: begin
          if (bit_en && active) begin
            shreg <= {1'b0, shreg[FRAME_W-1:1]};
            cnt   <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assert_pd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (line_idle && !ser_out));

  assert_hold_between_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !pwr_down) |=> $stable(ser_out));

  assert_stop_bit_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt == LAST) |-> !ser_out);
endmodule

// File: rtl/emb_clk_serializer.sv
module emb_clk_serializer
  import ser_pkg::*;
#(
  parameter int PAY_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             word_valid,
  output logic             word_ready,
  input  logic [PAY_W-1:0] word_data,
  input  logic             train_req_a,
  input  logic             train_req_b,
  input  logic             pwr_down,
  output logic             ser_out,
  output logic             line_idle
);
  localparam int FRAME_W = PAY_W + 2;

  shift_act_e         act;
  logic               at_boundary;
  logic [FRAME_W-1:0] frame;

  ser_word_ctl u_ctl (
    .bit_en      (bit_en),
    .at_boundary (at_boundary),
    .pwr_down    (pwr_down),
    .train_req_a (train_req_a),
    .train_req_b (train_req_b),
    .word_valid  (word_valid),
    .word_ready  (word_ready),
    .act         (act)
  );

  ser_frame_fmt #(.PAY_W(PAY_W)) u_fmt (
    .pay_in (word_data),
    .train  (act == ACT_TRAIN),
    .frame  (frame)
  );

  ser_bit_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .pwr_down    (pwr_down),
    .act         (act),
    .frame_in    (frame),
    .ser_out     (ser_out),
    .line_idle   (line_idle),
    .at_boundary (at_boundary)
  );

  assert_start_bit_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> (ser_out && !line_idle));
endmodule

// File: tb/emb_clk_serializer_tb_top.sv
`timescale 1ns/1ps
module emb_clk_serializer_tb_top;
  localparam int PAY_W = 10;
  localparam int FW    = PAY_W + 2;
  localparam int DIV   = 3;
  localparam logic [PAY_W-1:0] TRAIN_PAT = 10'h01F;

  logic clk = 0, rst_n = 0, bit_en = 0;
  logic word_valid = 0, train_req_a = 0, train_req_b = 0, pwr_down = 0;
  logic [PAY_W-1:0] word_data = '0;
  logic word_ready, ser_out, line_idle;

  int n_chk = 0, n_fail = 0;
  logic [PAY_W-1:0] exp_q[$];
  bit train_win = 0, pd_hit = 0, burst_chk = 0, finished = 0;
  int train_cnt = 0, train_take_hits = 0, burst_frames = 0;
  int strobe_idx = 0, start_idx = 0, prev_start = 0, nbits = 0;
  logic [FW-1:0] rx;
  int div_cnt = 0;

  always #4 clk = ~clk;

  emb_clk_serializer #(.PAY_W(PAY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_valid(word_valid),
    .word_ready(word_ready), .word_data(word_data), .train_req_a(train_req_a),
    .train_req_b(train_req_b), .pwr_down(pwr_down), .ser_out(ser_out),
    .line_idle(line_idle));

  always @(posedge clk) begin
    div_cnt <= (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
    bit_en  <= (div_cnt == DIV - 1);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: decode frames from the line at each strobe cycle.
  always @(negedge clk) begin
    if (rst_n && bit_en) begin
      strobe_idx++;
      if (line_idle) begin
        if (nbits != 0) begin
          if (pd_hit) begin
            if (exp_q.size() != 0) void'(exp_q.pop_front());
            pd_hit = 0;
          end else chk(0, "R1 truncated frame", nbits, FW);
          nbits = 0;
        end
      end else begin
        if (nbits == 0) start_idx = strobe_idx;
        rx[nbits] = ser_out;
        nbits++;
        if (nbits == FW) begin
          nbits = 0;
          chk(rx[0] == 1'b1 && rx[FW-1] == 1'b0, "R1 clock bits", {rx[FW-1], rx[0]}, 1);
          if (rx[FW-2:1] == TRAIN_PAT && train_win) begin
            train_cnt++;
          end else if (exp_q.size() == 0) begin
            chk(0, "R2 unexpected frame", rx[FW-2:1], 0);
          end else begin
            logic [PAY_W-1:0] e;
            e = exp_q.pop_front();
            chk(rx[FW-2:1] == e, "R3 payload", rx[FW-2:1], e);
          end
          if (burst_chk) begin
            if (burst_frames > 0)
              chk(start_idx == prev_start + FW, "R9 back-to-back", start_idx - prev_start, FW);
            burst_frames++;
          end
          prev_start = start_idx;
        end
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && (train_req_a || train_req_b) && word_ready) train_take_hits++;
  end

  // Driver: called at a negedge; returns at a negedge after the handshake.
  task automatic send_word(input logic [PAY_W-1:0] w);
    word_valid = 1; word_data = w;
    forever begin
      #1;
      if (word_ready) begin
        exp_q.push_back(w);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    word_valid = 0; word_data = ~w;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    wait_cyc(5);
    chk(line_idle == 1 && ser_out == 0, "R8 reset state", {line_idle, ser_out}, 2'b10);
    rst_n = 1;
    wait_cyc(3);
    chk(line_idle == 1 && ser_out == 0, "R8 idle after reset", {line_idle, ser_out}, 2'b10);

    // R1 R3: single words with varied patterns
    send_word(10'h2A5);
    send_word(10'h155);
    send_word(10'h3C0);
    wait_cyc(FW * DIV * 3);
    // R6: stream stopped, line must be quiet
    chk(line_idle == 1 && ser_out == 0, "R6 idle when no word", {line_idle, ser_out}, 2'b10);
    chk(exp_q.size() == 0, "R2 all words sent", exp_q.size(), 0);

    // R6 resume after a gap
    send_word(10'h001);
    wait_cyc(DIV * 4);
    // R5: training raised mid-frame must not cut the word in flight
    train_win = 1; train_req_a = 1;
    word_valid = 1; word_data = 10'h0F0;   // held offer during training
    wait_cyc(FW * DIV * 4);
    chk(train_take_hits == 0, "R4 no take during training", train_take_hits, 0);
    chk(exp_q.size() == 0, "R5 frame in flight completed", exp_q.size(), 0);
    chk(train_cnt >= 2, "R4 training frames sent (req a)", train_cnt, 2);
    train_req_a = 0;
    send_word(10'h0F0);
    wait_cyc(FW * DIV * 2);
    train_win = 0;
    chk(exp_q.size() == 0, "R4 held word sent after training", exp_q.size(), 0);

    // R4 via the second request input
    train_cnt = 0; train_win = 1; train_req_b = 1;
    wait_cyc(FW * DIV * 3);
    chk(train_cnt >= 2, "R4 training frames sent (req b)", train_cnt, 2);
    train_req_b = 0;
    wait_cyc(FW * DIV * 2);
    train_win = 0;

    // R9: burst with a word offered at every boundary
    wait_cyc(DIV * 4);
    burst_chk = 1; burst_frames = 0;
    send_word(10'h3FE);
    send_word(10'h201);
    send_word(10'h0AA);
    send_word(10'h333);
    wait_cyc(FW * DIV * 2);
    burst_chk = 0;
    chk(burst_frames == 4, "R9 burst frame count", burst_frames, 4);

    // R7: power-down mid-frame
    send_word(10'h246);
    wait_cyc(DIV * 5);
    pd_hit = 1; pwr_down = 1;
    word_valid = 1; word_data = 10'h111;
    wait_cyc(2);
    chk(line_idle == 1 && ser_out == 0, "R7 quiet in power-down", {line_idle, ser_out}, 2'b10);
    chk(word_ready == 0, "R7 no take in power-down", word_ready, 0);
    wait_cyc(FW * DIV * 2);
    chk(exp_q.size() == 0 && pd_hit == 0, "R7 partial frame dropped", exp_q.size(), 0);
    pwr_down = 0;
    send_word(10'h111);
    wait_cyc(FW * DIV * 2);
    chk(exp_q.size() == 0, "R7 frame after release", exp_q.size(), 0);
    chk(line_idle == 1 && ser_out == 0, "R6 idle at end", {line_idle, ser_out}, 2'b10);
    finish_run();
  end
endmodule